// File: doc/BRIEF.md
# Three-Group Masked Interrupt Controller

This block gathers single-cycle interrupt strobes from peripherals into three 8-bit groups: two normal groups (A and B) and one fast group (F). Each group keeps a sticky status register, in which a strobe sets its bit whatever the mask, and a mask register. A group's request is its status ANDed with its mask. The block drives two lines to the processor. The normal line carries the OR of the group A and group B requests. The fast line carries the group F request. Both lines are registered.

Software reaches the registers over a plain byte-wide register bus addressed by word index. Reads are combinational from the index. Writes take effect at the clock edge where the write enable is high. Only group A has a write-to-clear register. Group A bit 7 always reads as set. Group F bit 7 is a force input that latches like any other source. The sources, the peripherals behind them and the processor are outside this block. The block has no data stream, so it has no valid/ready interface. Every pin is a plain control or status pin.

Source bit meaning (fixed by the register layout the software decodes):
- Group A: 0 printer busy, 1 serial ring, 2 printer acknowledge, 3 vertical blank, 4 reset, 5 timer 0, 6 timer 1, 7 always one.
- Group B: 0 expansion fast request, 1 sound buffer empty, 2 serial, 3 disc, 4 disc change, 5 expansion interrupt, 6 keyboard transmit empty, 7 keyboard receive full.
- Group F: 0 floppy data request, 1 floppy, 2 network, 6 expansion, 7 force. Bits 3 to 5 latch like any other bit.

Top module: `tri_group_irqc`

## Requirements
- R1: After reset, group A status reads 0x80, group B and F status read 0x00, and all masks read 0x00. Both interrupt lines are low.
- R2: A strobe high on a source bit at a clock edge sets the matching status bit whatever the mask. The bit stays set until it is cleared. Status is read at index 4 (A), 8 (B) and 12 (F).
- R3: The mask registers are at index 6 (A), 10 (B) and 14 (F). A write there stores the byte, and a read returns it. No other write changes a mask.
- R4: A read at index 5 (A), 9 (B) or 13 (F) returns that group's status AND mask.
- R5: A write to index 5 clears each group A status bit that is 1 in the written byte. Group A bit 7 stays 1. A strobe arriving in the same cycle as the clear wins, and its bit ends set.
- R6: Writes to indices 4, 8, 9, 12 and 13 change no status bit. Group B and F status bits never clear once set (reset aside).
- R7: The normal line at each edge takes the value (A request non-zero) OR (B request non-zero), computed from the register state before that edge. It therefore follows a state change one cycle later.
- R8: The fast line at each edge takes the value (F request non-zero), computed from the register state before that edge.
- R9: A read of any index other than 4, 5, 6, 8, 9, 10, 12, 13 or 14 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 8 | Group A source strobes |
| src_b | input | 8 | Group B source strobes |
| src_f | input | 8 | Group F source strobes |
| reg_wen | input | 1 | Register write enable |
| reg_idx | input | 5 | Register word index for read and write |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte for reg_idx (combinational) |
| irq_norm | output | 1 | Registered normal interrupt line |
| irq_fast | output | 1 | Registered fast interrupt line |

## Verification
The assertions check four things on every cycle. Group A bit 7 is always set. Group B and F status bits never fall. A mask changes only when its own index is written. Each interrupt line equals the request OR-reduction of the previous cycle.

Three behaviours need the bench's scenarios, because they depend on what software writes and reads back:
- the exact bits removed by a clear write, and a strobe winning over a clear in the same cycle;
- request readback as status AND mask;
- zero data from unmapped indices.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned NGRP  = 3;

  // group order: A, B, F
  localparam int unsigned GRP_A = 0;
  localparam int unsigned GRP_B = 1;
  localparam int unsigned GRP_F = 2;

  // register triplet: status at base, request at base+1, mask at base+2
  localparam int unsigned BASE_A = 4;
  localparam int unsigned BASE_B = 8;
  localparam int unsigned BASE_F = 12;
  localparam int unsigned OFS_REQ = 1;
  localparam int unsigned OFS_MSK = 2;

  function automatic int unsigned grp_base(int unsigned g);
    case (g)
      GRP_A:   grp_base = BASE_A;
      GRP_B:   grp_base = BASE_B;
      default: grp_base = BASE_F;
    endcase
  endfunction

  // group A bit 7 is permanently set
  localparam logic [DW-1:0] A_STUCK = 8'h80;
endpackage

// File: rtl/irqc_group.sv
module irqc_group
  import irqc_pkg::*;
#(
  parameter int unsigned    BASE     = 4,
  parameter logic [DW-1:0]  STUCK    = '0,
  parameter bit             HAS_CLR  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    ev,
  input  logic             wen,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    status,
  output logic [DW-1:0]    mask,
  output logic [DW-1:0]    req
);
  localparam logic [IDX_W-1:0] CLR_IDX = IDX_W'(BASE + OFS_REQ);
  localparam logic [IDX_W-1:0] MSK_IDX = IDX_W'(BASE + OFS_MSK);

  logic [DW-1:0] clr_bits;
  logic [DW-1:0] status_nx;

  generate
    if (HAS_CLR) begin : g_clr
      assign clr_bits = (wen && idx == CLR_IDX) ? wdata : '0;
    end else begin : g_noclr
      assign clr_bits = '0;
    end
  endgenerate

  // a strobe in the same cycle beats the clear
  assign status_nx = (status & ~clr_bits) | ev | STUCK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= STUCK;
      mask   <= '0;
    end else begin
      status <= status_nx;
      if (wen && idx == MSK_IDX) mask <= wdata;
    end
  end

  assign req = status & mask;
endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
  import irqc_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    st  [NGRP],
  input  logic [DW-1:0]    mk  [NGRP],
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] part [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_part
    localparam int unsigned B = grp_base(g);
    always_comb begin
      part[g] = '0;
      if (idx == IDX_W'(B))                 part[g] = st[g];
      else if (idx == IDX_W'(B + OFS_REQ))  part[g] = st[g] & mk[g];
      else if (idx == IDX_W'(B + OFS_MSK))  part[g] = mk[g];
    end
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < NGRP; g++) rdata = rdata | part[g];
  end
endmodule

// File: rtl/tri_group_irqc.sv
module tri_group_irqc
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       src_a,
  input  logic [7:0]       src_b,
  input  logic [7:0]       src_f,
  input  logic             reg_wen,
  input  logic [4:0]       reg_idx,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq_norm,
  output logic             irq_fast
);
  logic [DW-1:0] grp_st  [NGRP];
  logic [DW-1:0] grp_mk  [NGRP];
  logic [DW-1:0] grp_req [NGRP];
  logic [DW-1:0] grp_ev  [NGRP];

  assign grp_ev[GRP_A] = src_a;
  assign grp_ev[GRP_B] = src_b;
  assign grp_ev[GRP_F] = src_f;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    irqc_group #(
      .BASE    (grp_base(g)),
      .STUCK   ((g == GRP_A) ? A_STUCK : '0),
      .HAS_CLR (g == GRP_A)
    ) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (grp_ev[g]),
      .wen    (reg_wen),
      .idx    (reg_idx),
      .wdata  (reg_wdata),
      .status (grp_st[g]),
      .mask   (grp_mk[g]),
      .req    (grp_req[g])
    );
  end

  irqc_rdmux u_rd (
    .idx   (reg_idx),
    .st    (grp_st),
    .mk    (grp_mk),
    .rdata (reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_norm <= 1'b0;
      irq_fast <= 1'b0;
    end else begin
      irq_norm <= (|grp_req[GRP_A]) | (|grp_req[GRP_B]);
      irq_fast <= |grp_req[GRP_F];
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wen,
  input logic [4:0] reg_idx,
  input logic [7:0] st_a,
  input logic [7:0] st_b,
  input logic [7:0] st_f,
  input logic [7:0] mk_a,
  input logic [7:0] mk_b,
  input logic [7:0] mk_f,
  input logic       irq_norm,
  input logic       irq_fast
);
  a_r5_a_bit7_set: assert property (@(posedge clk) disable iff (!rst_n)
    st_a[7] == 1'b1);

  a_r6_b_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(st_b) & ~st_b) == 8'h00) && (($past(st_f) & ~st_f) == 8'h00)));

  a_r3_mask_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wen && reg_idx == 5'd6) |=> $stable(mk_a));
  a_r3_mask_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wen && reg_idx == 5'd10) |=> $stable(mk_b));
  a_r3_mask_f_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wen && reg_idx == 5'd14) |=> $stable(mk_f));

  a_r7_norm_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_norm == ($past(|(st_a & mk_a)) || $past(|(st_b & mk_b)))));

  a_r8_fast_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_fast == $past(|(st_f & mk_f))));
endmodule

bind tri_group_irqc irqc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wen  (reg_wen),
  .reg_idx  (reg_idx),
  .st_a     (grp_st[0]),
  .st_b     (grp_st[1]),
  .st_f     (grp_st[2]),
  .mk_a     (grp_mk[0]),
  .mk_b     (grp_mk[1]),
  .mk_f     (grp_mk[2]),
  .irq_norm (irq_norm),
  .irq_fast (irq_fast)
);

// File: tb/sim_tri_group_irqc.sv
module sim_tri_group_irqc;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] src_a = 0, src_b = 0, src_f = 0;
  logic reg_wen = 0;
  logic [4:0] reg_idx = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq_norm, irq_fast;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_st [3];
  logic [7:0] m_mk [3];
  logic m_norm, m_fast;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_group_irqc u0 (
    .clk(clk), .rst_n(rst_n),
    .src_a(src_a), .src_b(src_b), .src_f(src_f),
    .reg_wen(reg_wen), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_norm(irq_norm), .irq_fast(irq_fast)
  );

  function automatic logic [7:0] exp_read(logic [4:0] i);
    case (i)
      5'd4:  return m_st[0];
      5'd5:  return m_st[0] & m_mk[0];
      5'd6:  return m_mk[0];
      5'd8:  return m_st[1];
      5'd9:  return m_st[1] & m_mk[1];
      5'd10: return m_mk[1];
      5'd12: return m_st[2];
      5'd13: return m_st[2] & m_mk[2];
      5'd14: return m_mk[2];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(logic [4:0] i);
    case (i)
      5'd4, 5'd8, 5'd12:  return "R2";
      5'd5, 5'd9, 5'd13:  return "R4";
      5'd6, 5'd10, 5'd14: return "R3";
      default:            return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // model update for one clock edge using the inputs currently driven
  task automatic model_edge();
    logic [7:0] clr;
    m_norm = (|(m_st[0] & m_mk[0])) | (|(m_st[1] & m_mk[1]));
    m_fast = |(m_st[2] & m_mk[2]);
    clr = (reg_wen && reg_idx == 5'd5) ? reg_wdata : 8'h00;
    m_st[0] = (m_st[0] & ~clr) | src_a | 8'h80;
    m_st[1] = m_st[1] | src_b;
    m_st[2] = m_st[2] | src_f;
    if (reg_wen && reg_idx == 5'd6)  m_mk[0] = reg_wdata;
    if (reg_wen && reg_idx == 5'd10) m_mk[1] = reg_wdata;
    if (reg_wen && reg_idx == 5'd14) m_mk[2] = reg_wdata;
  endtask

  // drive at negedge, step one edge, check at next negedge
  task automatic step(logic [7:0] a, logic [7:0] b, logic [7:0] f,
                      logic w, logic [4:0] i, logic [7:0] d);
    src_a = a; src_b = b; src_f = f;
    reg_wen = w; reg_idx = i; reg_wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(read_tag(i), reg_rdata, exp_read(i));
    check("R7", {7'd0, irq_norm}, {7'd0, m_norm});
    check("R8", {7'd0, irq_fast}, {7'd0, m_fast});
  endtask

  task automatic peek(logic [4:0] i, string tag, logic [7:0] exp);
    src_a = 0; src_b = 0; src_f = 0; reg_wen = 0; reg_idx = i;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_st[0] = 8'h80; m_st[1] = 0; m_st[2] = 0;
    m_mk[0] = 0; m_mk[1] = 0; m_mk[2] = 0;
    m_norm = 0; m_fast = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    peek(5'd4, "R1", 8'h80);
    peek(5'd8, "R1", 8'h00);
    peek(5'd12, "R1", 8'h00);
    peek(5'd6, "R1", 8'h00);
    peek(5'd10, "R1", 8'h00);
    peek(5'd14, "R1", 8'h00);
    check("R1", {6'd0, irq_norm, irq_fast}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: strobe with mask clear still latches, no interrupt
    step(8'h21, 8'h00, 8'h00, 0, 5'd4, 8'h00);
    step(8'h00, 8'h00, 8'h00, 0, 5'd4, 8'h00);
    check("R2", {7'd0, irq_norm}, 8'h00);
    // R3/R7: unmask B bit 1 after a B event
    step(8'h00, 8'h02, 8'h00, 1, 5'd10, 8'h02);
    step(8'h00, 8'h00, 8'h00, 0, 5'd9, 8'h00);
    step(8'h00, 8'h00, 8'h00, 0, 5'd9, 8'h00);
    check("R7", {7'd0, irq_norm}, 8'h01);
    // R6: write to B status/request does not clear
    step(8'h00, 8'h00, 8'h00, 1, 5'd9, 8'hff);
    step(8'h00, 8'h00, 8'h00, 1, 5'd8, 8'hff);
    peek(5'd8, "R6", 8'h02);
    // R8: fast line through force bit
    step(8'h00, 8'h00, 8'h80, 1, 5'd14, 8'h80);
    step(8'h00, 8'h00, 8'h00, 0, 5'd13, 8'h00);
    step(8'h00, 8'h00, 8'h00, 0, 5'd13, 8'h00);
    check("R8", {7'd0, irq_fast}, 8'h01);
    // R5: clear all of A, bit 7 stays; same-cycle strobe wins
    step(8'h40, 8'h00, 8'h00, 1, 5'd5, 8'hff);
    peek(5'd4, "R5", 8'hc0);
    step(8'h00, 8'h00, 8'h00, 1, 5'd5, 8'h40);
    peek(5'd4, "R5", 8'h80);
    // R5/R7: bit 7 unmasked drives normal line
    step(8'h00, 8'h00, 8'h00, 1, 5'd6, 8'h80);
    step(8'h00, 8'h00, 8'h00, 0, 5'd5, 8'h00);
    peek(5'd5, "R5", 8'h80);
    // R9: unmapped indices
    peek(5'd0, "R9", 8'h00);
    peek(5'd7, "R9", 8'h00);
    peek(5'd31, "R9", 8'h00);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a, b, f, d;
      logic w;
      logic [4:0] i;
      a = 8'($urandom) & 8'($urandom) & 8'($urandom);
      b = 8'($urandom) & 8'($urandom) & 8'($urandom);
      f = 8'($urandom) & 8'($urandom) & 8'($urandom);
      w = ($urandom % 10) < 3;
      i = ($urandom % 3 == 0) ? 5'd5 : 5'($urandom);
      d = 8'($urandom);
      step(a, b, f, w, i, d);
    end

    done = 1;
    finish_sim();
  end
endmodule